// File: doc/BRIEF.md
# Dual Retriggerable Phase Interval Timer

This block times the phases of a four-road signal sequencer. It holds two independent one-shot timers, one for the long green/red phase and one for the short yellow phase. Each timer has its own trigger level. The sequencer drives the long trigger high when it enters any green/red state and the short trigger high when it enters any yellow state. The two triggers are never high together.

On a rising edge of a trigger, the matching timer loads its full count. It holds its busy output high for that many clock cycles and then gives a one-cycle done pulse. The busy outputs return to the sequencer as its long-timer and short-timer inputs. The time base is a 10 kHz clock. The default lengths of 200000 and 40000 cycles give 20 s and 4 s, and both lengths are parameters so a bench can shorten them.

Top module: `phase_interval_timer`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next cycle has all four outputs low: both busy outputs and both done outputs.
- R2: A trigger that is already high when reset is released starts no timer. Only a later low-to-high change on that trigger does.
- R3: A rising edge on `long_trig` makes `long_busy` high for exactly LONG_CYCLES consecutive cycles. The edge is sampled at a clock edge, and `long_busy` goes high in the cycle after that clock edge.
- R4: A rising edge on `short_trig` makes `short_busy` high for exactly SHORT_CYCLES consecutive cycles, with the same start timing as R3.
- R5: A timer's done output is high for exactly one cycle. That cycle is the first cycle in which its busy output is low after a run that expired, and done is never high while busy is high.
- R6: Holding a trigger high gives only one run. After that run expires, busy stays low until the trigger falls and rises again.
- R7: A new rising edge during a run reloads the full count. Busy stays high through the reload, and the cut-short run gives no done pulse.
- R8: The two timers are independent. Starting, running or expiring one timer does not change the other timer's busy or done outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Time-base clock (10 kHz in the target system) |
| rst | input | 1 | Synchronous active-high reset |
| long_trig | input | 1 | Level that rises on entry to a green/red phase |
| short_trig | input | 1 | Level that rises on entry to a yellow phase |
| long_busy | output | 1 | High while the long interval runs |
| short_busy | output | 1 | High while the short interval runs |
| long_done | output | 1 | One-cycle pulse when the long interval expires |
| short_done | output | 1 | One-cycle pulse when the short interval expires |

## Verification
The bench measures each busy window cycle by cycle with shortened lengths. An off-by-one load or decrement shows up as a window one cycle too long or too short. A trigger held high through reset catches an edge detector that clears its history to zero, because that design would start a timer right after reset. A trigger held high past expiry catches a design that responds to the level instead of the edge. A fall and rise in the middle of a run checks that the count reloads and that no done pulse appears at the moment of reload. Overlapping long and short runs would expose any counter or done logic shared between the two timers.

// File: rtl/phase_interval_timer.sv
module phase_interval_timer #(
  parameter int LONG_CYCLES  = 200000,
  parameter int SHORT_CYCLES = 40000
) (
  input  logic clk,
  input  logic rst,
  input  logic long_trig,
  input  logic short_trig,
  output logic long_busy,
  output logic short_busy,
  output logic long_done,
  output logic short_done
);
  localparam int MAXLEN = (LONG_CYCLES > SHORT_CYCLES) ? LONG_CYCLES : SHORT_CYCLES;
  localparam int CW = $clog2(MAXLEN + 1);

  logic       armed;
  logic [1:0] trig, prev, rise, busy, done;

  assign trig = {short_trig, long_trig};
  assign rise = trig & ~prev & {2{armed}};

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      prev  <= '0;
    end else begin
      armed <= 1'b1;
      prev  <= trig;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_chan
    localparam int LEN = (g == 0) ? LONG_CYCLES : SHORT_CYCLES;
    localparam logic [CW-1:0] LOAD = CW'(LEN);
    logic [CW-1:0] cnt;
    logic          done_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt    <= '0;
        done_q <= 1'b0;
      end else if (rise[g]) begin
        cnt    <= LOAD;
        done_q <= 1'b0;
      end else if (cnt != '0) begin
        cnt    <= cnt - 1'b1;
        done_q <= (cnt == CW'(1));
      end else begin
        done_q <= 1'b0;
      end
    end

    assign busy[g] = (cnt != '0);
    assign done[g] = done_q;
  end

  assign long_busy  = busy[0];
  assign short_busy = busy[1];
  assign long_done  = done[0];
  assign short_done = done[1];
endmodule

module phase_interval_timer_chk (
  input logic clk,
  input logic rst,
  input logic long_trig,
  input logic short_trig,
  input logic long_busy,
  input logic short_busy,
  input logic long_done,
  input logic short_done
);
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!long_busy && !short_busy && !long_done && !short_done));

  p_long_start_r3: assert property (@(posedge clk) disable iff (rst)
    (long_trig && !$past(long_trig) && !$past(rst)) |=> long_busy);

  p_short_start_r4: assert property (@(posedge clk) disable iff (rst)
    (short_trig && !$past(short_trig) && !$past(rst)) |=> short_busy);

  p_long_done_after_busy_r5: assert property (@(posedge clk) disable iff (rst)
    long_done |-> (!long_busy && $past(long_busy)));

  p_short_done_after_busy_r5: assert property (@(posedge clk) disable iff (rst)
    short_done |-> (!short_busy && $past(short_busy)));

  p_long_done_single_r5: assert property (@(posedge clk) disable iff (rst)
    long_done |=> !long_done);

  p_short_done_single_r5: assert property (@(posedge clk) disable iff (rst)
    short_done |=> !short_done);

  p_long_fall_done_r7: assert property (@(posedge clk) disable iff (rst)
    ($fell(long_busy) && !$past(rst)) |-> long_done);

  p_short_fall_done_r7: assert property (@(posedge clk) disable iff (rst)
    ($fell(short_busy) && !$past(rst)) |-> short_done);
endmodule

bind phase_interval_timer phase_interval_timer_chk u_chk (
  .clk(clk), .rst(rst), .long_trig(long_trig), .short_trig(short_trig),
  .long_busy(long_busy), .short_busy(short_busy),
  .long_done(long_done), .short_done(short_done)
);

// File: tb/phase_interval_timer_test.sv
module phase_interval_timer_test;
  localparam int L = 12;
  localparam int S = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic long_trig = 1'b0;
  logic short_trig = 1'b0;
  logic long_busy, short_busy, long_done, short_done;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  phase_interval_timer #(.LONG_CYCLES(L), .SHORT_CYCLES(S)) uut (
    .clk(clk), .rst(rst), .long_trig(long_trig), .short_trig(short_trig),
    .long_busy(long_busy), .short_busy(short_busy),
    .long_done(long_done), .short_done(short_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_trig(input int ch, input logic v);
    if (ch == 0) long_trig = v; else short_trig = v;
  endtask

  function automatic logic busy_of(input int ch);
    return (ch == 0) ? long_busy : short_busy;
  endfunction

  function automatic logic done_of(input int ch);
    return (ch == 0) ? long_done : short_done;
  endfunction

  task automatic measure(input int ch, input int exp, input string req);
    int width = 0;
    int early_done = 0;
    @(negedge clk);
    while (busy_of(ch) && width < exp + 20) begin
      if (done_of(ch)) early_done++;
      width++;
      @(negedge clk);
    end
    check(width == exp, req, width, exp);
    check(early_done == 0, "R5 no done while busy", early_done, 0);
    check(done_of(ch) == 1'b1, "R5 done at expiry", done_of(ch), 1);
    @(negedge clk);
    check(done_of(ch) == 1'b0, "R5 done one cycle", done_of(ch), 0);
  endtask

  task automatic idle(input int n);
    long_trig = 1'b0;
    short_trig = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state();
    int bad = 0;
    rst = 1'b1;
    long_trig = 1'b1;
    short_trig = 1'b0;
    repeat (3) @(negedge clk);
    check({long_busy, short_busy, long_done, short_done} == 4'b0, "R1 reset outputs",
          {long_busy, short_busy, long_done, short_done}, 0);
    rst = 1'b0;
    repeat (L + 4) begin
      @(negedge clk);
      if (long_busy || long_done) bad++;
    end
    check(bad == 0, "R2 no start from held trigger", bad, 0);
    idle(2);
  endtask

  task automatic t_long_width();
    set_trig(0, 1'b1);
    measure(0, L, "R3 long width");
    set_trig(0, 1'b0);
    idle(2);
  endtask

  task automatic t_short_width();
    set_trig(1, 1'b1);
    measure(1, S, "R4 short width");
    idle(2);
  endtask

  task automatic t_level_hold();
    int bad = 0;
    set_trig(1, 1'b1);
    measure(1, S, "R6 first run width");
    repeat (3 * S) begin
      @(negedge clk);
      if (short_busy) bad++;
    end
    check(bad == 0, "R6 held level no restart", bad, 0);
    idle(2);
  endtask

  task automatic t_retrigger();
    int width = 1;
    int mid_done = 0;
    short_trig = 1'b1;
    @(negedge clk);
    @(negedge clk);
    short_trig = 1'b0;
    @(negedge clk);
    short_trig = 1'b1;
    width = 3;
    if (short_done) mid_done++;
    @(negedge clk);
    while (short_busy && width < S + 20) begin
      if (short_done) mid_done++;
      width++;
      @(negedge clk);
    end
    check(width == S + 3, "R7 retrigger extends window", width, S + 3);
    check(mid_done == 0, "R7 no done at reload", mid_done, 0);
    check(short_done == 1'b1, "R7 done after extended run", short_done, 1);
    idle(3);
  endtask

  task automatic t_independent();
    int bad_l = 0;
    int bad_s = 0;
    long_trig = 1'b1;
    for (int k = 1; k <= L + 3; k++) begin
      @(negedge clk);
      if (k == 2) short_trig = 1'b1;
      if (long_busy != (k >= 1 && k <= L)) bad_l++;
      if (long_done != (k == L + 1)) bad_l++;
      if (short_busy != (k >= 3 && k <= S + 2)) bad_s++;
      if (short_done != (k == S + 3)) bad_s++;
    end
    check(bad_l == 0, "R8 long unaffected by short", bad_l, 0);
    check(bad_s == 0, "R8 short unaffected by long", bad_s, 0);
    idle(2);
  endtask

  task automatic t_reset_mid_run();
    int bad = 0;
    long_trig = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check({long_busy, long_done} == 2'b0, "R1 reset aborts run", {long_busy, long_done}, 0);
    rst = 1'b0;
    repeat (L + 3) begin
      @(negedge clk);
      if (long_busy || long_done) bad++;
    end
    check(bad == 0, "R2 no restart after mid-run reset", bad, 0);
    idle(2);
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_long_width();
        t_short_width();
        t_level_hold();
        t_retrigger();
        t_independent();
        t_reset_mid_run();
      end
      begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule